// File: doc/BRIEF.md
# Multi-Radix Scanned Seven-Segment Display Driver

This block shows one byte on a row of eight seven-segment digits. Only one digit is lit at a time. A free-running refresh counter steps through the digits quickly enough that all eight appear to be lit together. A two-bit presentation code selects the format. The byte can appear as eight separate bit digits, as a three-place decimal number, or as two hexadecimal digits. A fourth code turns the whole row dark.

The digit enables and the segment lines are active low. The glyph for the active digit is built from the byte and the presentation code. It is registered together with the digit enable, so both change on the same clock edge and no segment pattern reaches a neighbouring digit. Three status LEDs report which presentation is active.

The block works at a plain control level. `value` and `mode` are sampled on every clock and have no handshake. It consumes them continuously and cannot apply back-pressure. Reset is synchronous and active high.

Top module: `sevseg_mux_ctrl`

## Requirements
- R1: While `rst` is high, each clock edge sets `dig_n` to 8'hFE, `seg_n` to 8'hFF and `mode_led` to 3'b000, and clears the refresh counter.
- R2: Exactly one bit of `dig_n` is low at all times. The low bit is the digit index, taken from the top three bits of the CNT_W-bit refresh counter. It advances 0,1,...,7 and wraps to 0, and each digit stays active for 2^(CNT_W-3) clocks. Digit 0 is the rightmost position.
- R3: `seg_n` bits 7..1 drive segments A..G and bit 0 drives the decimal point. The decimal point is always off (bit 0 high). For nibble n the active-high ABCDEFG pattern is 7E,30,6D,79,33,5B,5F,70,7F,7B,77,1F,4E,3D,4F,47 for n = 0..F, and `seg_n` is the bitwise inverse of {pattern, 1'b0}. A blank digit has `seg_n` = 8'hFF.
- R4: With `mode` = 0 (binary), digit d shows the glyph 0 or 1 according to `value[d]`.
- R5: With `mode` = 1 (decimal), digit 0 shows the ones, digit 1 the tens and digit 2 the hundreds of `value`, with zeros shown. Digits 3..7 are blank.
- R6: With `mode` = 2 (hex), digit 0 shows `value[3:0]` and digit 1 shows `value[7:4]`. Digits 2..7 are blank.
- R7: With `mode` = 3, every digit is blank.
- R8: `mode_led` is 3'b001, 3'b010, 3'b100 or 3'b000 for `mode` 0, 1, 2 or 3.
- R9: `dig_n`, `seg_n` and `mode_led` are registered. A change on `value` or `mode` shows up on the outputs one clock edge later, and the segment pattern changes on the same edge as the digit enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| value | input | 8 | Byte to display |
| mode | input | 2 | Presentation: 0 binary, 1 decimal, 2 hex, 3 dark |
| dig_n | output | 8 | Digit enables, active low, one-hot low |
| seg_n | output | 8 | Segments A..G in bits 7..1, decimal point in bit 0, active low |
| mode_led | output | 3 | Status LEDs for the active presentation |

## Verification
The hardest situation to reach from the ports is the content of each digit for every presentation. A digit is visible only during its own slot of the scan, and with the default counter width a single slot lasts more than a hundred thousand clocks. The bench therefore builds the block with a six-bit refresh counter. For each byte and mode it then follows `dig_n` until each digit in turn becomes active and compares `seg_n` there. The boundary bytes (0, 7, 100, 209, 255) exercise the decimal carries. A value change in the middle of a slot exposes the one-edge latency without the digit moving.

// File: rtl/sevseg_pkg.sv
package sevseg_pkg;

  typedef enum logic [1:0] {
    MD_BIN = 2'd0,
    MD_DEC = 2'd1,
    MD_HEX = 2'd2,
    MD_OFF = 2'd3
  } mode_e;

  // active-high A..G pattern for one nibble
  function automatic logic [6:0] glyph7(input logic [3:0] n);
    case (n)
      4'h0: glyph7 = 7'h7E;
      4'h1: glyph7 = 7'h30;
      4'h2: glyph7 = 7'h6D;
      4'h3: glyph7 = 7'h79;
      4'h4: glyph7 = 7'h33;
      4'h5: glyph7 = 7'h5B;
      4'h6: glyph7 = 7'h5F;
      4'h7: glyph7 = 7'h70;
      4'h8: glyph7 = 7'h7F;
      4'h9: glyph7 = 7'h7B;
      4'hA: glyph7 = 7'h77;
      4'hB: glyph7 = 7'h1F;
      4'hC: glyph7 = 7'h4E;
      4'hD: glyph7 = 7'h3D;
      4'hE: glyph7 = 7'h4F;
      default: glyph7 = 7'h47;
    endcase
  endfunction

  // number of decimal places needed for an unsigned w-bit value
  function automatic int dec_places(input int w);
    longint m;
    int n;
    m = (longint'(1) << w) - 1;
    n = 1;
    while (m >= 10) begin
      m = m / 10;
      n = n + 1;
    end
    return n;
  endfunction

endpackage

// File: rtl/sevseg_scan.sv
module sevseg_scan #(
  parameter int CNT_W = 20,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  output logic [IDX_W-1:0] idx
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + 1'b1;
  end

  assign idx = cnt_q[CNT_W-1 -: IDX_W];
endmodule

// File: rtl/sevseg_digit_map.sv
module sevseg_digit_map
  import sevseg_pkg::*;
#(
  parameter int VAL_W = 8,
  localparam int N_DIG = VAL_W,
  localparam int DEC_P = dec_places(VAL_W),
  localparam int HEX_P = (VAL_W + 3) / 4
) (
  input  logic [VAL_W-1:0]   value,
  input  logic [1:0]         mode,
  output logic [N_DIG*4-1:0] nibs,
  output logic [N_DIG-1:0]   blanks
);
  mode_e md;
  assign md = mode_e'(mode);

  for (genvar k = 0; k < N_DIG; k++) begin : g_dig
    logic [3:0] dec_nib;
    logic [3:0] hex_nib;

    if (k < DEC_P) begin : g_dec
      localparam int unsigned SCALE = 10 ** k;
      assign dec_nib = 4'((32'(value) / SCALE) % 10);
    end else begin : g_dec_none
      assign dec_nib = 4'h0;
    end

    if (k < HEX_P) begin : g_hex
      localparam int HI = (4 * k + 3 < VAL_W) ? 4 * k + 3 : VAL_W - 1;
      assign hex_nib = 4'(value[HI:4*k]);
    end else begin : g_hex_none
      assign hex_nib = 4'h0;
    end

    always_comb begin
      nibs[4*k +: 4] = 4'h0;
      blanks[k]      = 1'b1;
      case (md)
        MD_BIN: begin
          nibs[4*k +: 4] = {3'b000, value[k]};
          blanks[k]      = 1'b0;
        end
        MD_DEC: begin
          nibs[4*k +: 4] = dec_nib;
          blanks[k]      = (k >= DEC_P);
        end
        MD_HEX: begin
          nibs[4*k +: 4] = hex_nib;
          blanks[k]      = (k >= HEX_P);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sevseg_glyph.sv
module sevseg_glyph
  import sevseg_pkg::*;
(
  input  logic [3:0] nib,
  input  logic       blank,
  output logic [7:0] seg_n
);
  always_comb begin
    if (blank) seg_n = 8'hFF;
    else       seg_n = ~{glyph7(nib), 1'b0};
  end
endmodule

// File: rtl/sevseg_mux_ctrl.sv
module sevseg_mux_ctrl
  import sevseg_pkg::*;
#(
  parameter int CNT_W = 20,
  parameter int VAL_W = 8,
  localparam int N_DIG = VAL_W,
  localparam int IDX_W = $clog2(N_DIG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [VAL_W-1:0] value,
  input  logic [1:0]       mode,
  output logic [N_DIG-1:0] dig_n,
  output logic [7:0]       seg_n,
  output logic [2:0]       mode_led
);
  logic [IDX_W-1:0]   idx;
  logic [N_DIG*4-1:0] nibs;
  logic [N_DIG-1:0]   blanks;
  logic [3:0]         cur_nib;
  logic               cur_blank;
  logic [7:0]         seg_d;
  logic [N_DIG-1:0]   dig_d;
  logic [2:0]         led_d;

  sevseg_scan #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_scan (
    .clk (clk),
    .rst (rst),
    .idx (idx)
  );

  sevseg_digit_map #(.VAL_W(VAL_W)) u_map (
    .value  (value),
    .mode   (mode),
    .nibs   (nibs),
    .blanks (blanks)
  );

  assign cur_nib   = nibs[4*idx +: 4];
  assign cur_blank = blanks[idx];

  sevseg_glyph u_glyph (
    .nib   (cur_nib),
    .blank (cur_blank),
    .seg_n (seg_d)
  );

  assign dig_d = ~({{(N_DIG-1){1'b0}}, 1'b1} << idx);

  always_comb begin
    case (mode_e'(mode))
      MD_BIN:  led_d = 3'b001;
      MD_DEC:  led_d = 3'b010;
      MD_HEX:  led_d = 3'b100;
      default: led_d = 3'b000;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dig_n    <= ~{{(N_DIG-1){1'b0}}, 1'b1};
      seg_n    <= 8'hFF;
      mode_led <= 3'b000;
    end else begin
      dig_n    <= dig_d;
      seg_n    <= seg_d;
      mode_led <= led_d;
    end
  end
endmodule

// File: rtl/sevseg_mux_ctrl_chk.sv
module sevseg_mux_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] mode,
  input logic [7:0] dig_n,
  input logic [7:0] seg_n,
  input logic [2:0] mode_led
);
  logic       armed;
  logic [1:0] prev_mode;
  logic [7:0] prev_dig;

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
    prev_mode <= mode;
    prev_dig  <= dig_n;
  end

  AST_ONE_DIGIT_LOW: assert property (@(posedge clk) disable iff (rst)
    $countones(~dig_n) == 1); // R2

  AST_SCAN_ROTATE: assert property (@(posedge clk) disable iff (rst)
    armed && (dig_n != prev_dig) |-> dig_n == {prev_dig[6:0], prev_dig[7]}); // R2

  AST_DP_DARK: assert property (@(posedge clk) disable iff (rst)
    seg_n[0] == 1'b1); // R3

  AST_DEC_HIGH_BLANK: assert property (@(posedge clk) disable iff (rst)
    armed && prev_mode == 2'd1 && dig_n[2:0] == 3'b111 |-> seg_n == 8'hFF); // R5

  AST_HEX_HIGH_BLANK: assert property (@(posedge clk) disable iff (rst)
    armed && prev_mode == 2'd2 && dig_n[1:0] == 2'b11 |-> seg_n == 8'hFF); // R6

  AST_DARK_MODE: assert property (@(posedge clk) disable iff (rst)
    armed && prev_mode == 2'd3 |-> seg_n == 8'hFF); // R7

  AST_LED_CODE: assert property (@(posedge clk) disable iff (rst)
    armed |-> mode_led == ((prev_mode == 2'd3) ? 3'b000 : (3'b001 << prev_mode))); // R8
endmodule

bind sevseg_mux_ctrl sevseg_mux_ctrl_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .mode     (mode),
  .dig_n    (dig_n),
  .seg_n    (seg_n),
  .mode_led (mode_led)
);

// File: tb/tb_sevseg_mux_ctrl.sv
module tb_sevseg_mux_ctrl;
  localparam int CNT_W = 6;
  localparam int DWELL = 1 << (CNT_W - 3);
  localparam int NVEC  = 12;
  localparam logic [6:0] GLY [16] = '{7'h7E, 7'h30, 7'h6D, 7'h79, 7'h33, 7'h5B, 7'h5F, 7'h70,
                                      7'h7F, 7'h7B, 7'h77, 7'h1F, 7'h4E, 7'h3D, 7'h4F, 7'h47};
  // {mode, value}
  localparam logic [9:0] VEC [NVEC] = '{
    {2'd0, 8'hA5}, {2'd0, 8'h00}, {2'd1, 8'd255}, {2'd1, 8'd0},
    {2'd1, 8'd7},  {2'd1, 8'd100}, {2'd1, 8'd209}, {2'd2, 8'h3C},
    {2'd2, 8'hF0}, {2'd3, 8'hFF}, {2'd2, 8'h9E}, {2'd1, 8'd58}};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] value = 8'h00;
  logic [1:0] mode = 2'd0;
  logic [7:0] dig_n, seg_n;
  logic [2:0] mode_led;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sevseg_mux_ctrl #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .value(value), .mode(mode),
    .dig_n(dig_n), .seg_n(seg_n), .mode_led(mode_led));

  function automatic logic [7:0] pat(input logic [3:0] n);
    return ~{GLY[n], 1'b0};
  endfunction

  function automatic logic [7:0] exp_seg(input logic [1:0] m, input logic [7:0] v, input int d);
    int iv;
    iv = v;
    case (m)
      2'd0: return pat({3'b000, v[d]});
      2'd1: begin
        if (d == 0) return pat(4'(iv % 10));
        if (d == 1) return pat(4'((iv / 10) % 10));
        if (d == 2) return pat(4'(iv / 100));
        return 8'hFF;
      end
      2'd2: begin
        if (d == 0) return pat(v[3:0]);
        if (d == 1) return pat(v[7:4]);
        return 8'hFF;
      end
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [2:0] exp_led(input logic [1:0] m);
    return (m == 2'd3) ? 3'b000 : (3'b001 << m);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_digit(input int d);
    int n = 0;
    @(negedge clk);
    while (dig_n !== ~(8'b1 << d) && n < 200) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 dig_n", 32'(dig_n), 32'hFE);
    chk("R1 seg_n", 32'(seg_n), 32'hFF);
    chk("R1 mode_led", 32'(mode_led), 32'h0);

    // R2: dwell of digit 0 and digit 1 after release
    mode = 2'd2;
    value = 8'h21;
    rst = 1'b0;
    begin
      int n0 = 0;
      int n1 = 0;
      @(negedge clk);
      while (dig_n === 8'hFE && n0 < 100) begin n0++; @(negedge clk); end
      chk("R2 next digit", 32'(dig_n), 32'hFD);
      while (dig_n === 8'hFD && n1 < 100) begin n1++; @(negedge clk); end
      chk("R2 dwell digit0", n0, DWELL);
      chk("R2 dwell digit1", n1, DWELL);
      chk("R2 rotate to digit2", 32'(dig_n), 32'hFB);
    end

    // R3..R8 vector walk
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      mode  = VEC[i][9:8];
      value = VEC[i][7:0];
      @(negedge clk);
      chk("R8 mode_led", 32'(mode_led), 32'(exp_led(mode)));
      for (int d = 0; d < 8; d++) begin
        wait_digit(d);
        case (mode)
          2'd0: chk("R4 binary digit", 32'(seg_n), 32'(exp_seg(mode, value, d)));
          2'd1: chk("R5 decimal digit", 32'(seg_n), 32'(exp_seg(mode, value, d)));
          2'd2: chk("R6 hex digit", 32'(seg_n), 32'(exp_seg(mode, value, d)));
          default: chk("R7 dark digit", 32'(seg_n), 32'hFF);
        endcase
        chk("R3 decimal point off", 32'(seg_n[0]), 32'h1);
      end
    end

    // R9: value change in mid-slot reaches seg_n one edge later
    mode = 2'd2;
    value = 8'h00;
    wait_digit(1);
    wait_digit(0);
    value = 8'h0F;
    chk("R9 before edge", 32'(seg_n), 32'(pat(4'h0)));
    @(negedge clk);
    chk("R9 after edge", 32'(seg_n), 32'(pat(4'hF)));
    chk("R9 digit held", 32'(dig_n), 32'hFE);

    // R1: reset in mid-scan returns to digit 0, blank
    wait_digit(5);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid-scan dig_n", 32'(dig_n), 32'hFE);
    chk("R1 mid-scan seg_n", 32'(seg_n), 32'hFF);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 restart digit0", 32'(dig_n), 32'hFE);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule